// File: doc/BRIEF.md
# Color Bar and Bouncing Box Video Generator

This block produces a self-timed fallback video stream for the times when no usable external source is present. Free-running horizontal and vertical counters generate the raster timing. The default raster has 1920x1080 active pixels. The counters also produce sync pulses, blanking and a data-enable. During active video the block paints eight vertical color bars. A solid square is drawn on top of the bars. The square moves diagonally by a fixed step once per frame and reflects off the edges of the active area.

A one-bit select and a valid flag from the live source together choose what leaves the block. The output is either the live stream, registered once, or the generated pattern. The choice is sampled only on the first clock of a generated frame, so neither source is ever shown for part of a frame.

Pixels are 16 bits wide. The upper byte carries luma and the lower byte carries a chroma sample that alternates between the two chroma components, as in 4:2:2.

Top module: `colorbar_box_gen`

## Requirements
- R1: While rst_n is low the outputs are de=0, hs=0, vs=0 and data=16'h1080. The first clock edge after release outputs the pixel at column 0, line 0.
- R2: A line lasts H_ACTIVE+H_FRONT+H_SYNC+H_BACK clocks. In pattern mode, de is high for columns below H_ACTIVE on active lines. hs is high for the H_SYNC clocks that start at column H_ACTIVE+H_FRONT.
- R3: A frame lasts V_ACTIVE+V_FRONT+V_SYNC+V_BACK lines. vs is high on whole lines V_ACTIVE+V_FRONT through V_ACTIVE+V_FRONT+V_SYNC-1, and de stays low on every line from V_ACTIVE upward.
- R4: The active width is split into eight bars of H_ACTIVE/8 columns each. From the left they are white (Y 235, Cb 128, Cr 128), yellow (219,16,138), cyan (188,154,16), green (173,42,26), magenta (78,214,230), red (63,102,240), blue (32,240,118) and black (16,128,128).
- R5: Pixel data[15:8] is luma. data[7:0] is Cb on even columns and Cr on odd columns.
- R6: Pixels inside a BOX_SIZE x BOX_SIZE square whose top-left corner is at (box x, box y) take the color Y 81, Cb 90, Cr 240 instead of the bar color.
- R7: After reset the square is at (0,0) and moves toward larger x and y. It moves by BOX_STEP in each axis exactly once per frame, at column 0 of line V_ACTIVE, and stays still at all other times.
- R8: An axis moving toward larger values reverses and steps back by BOX_STEP if position+BOX_STEP+BOX_SIZE would exceed the active size. An axis moving toward smaller values reverses and steps forward by BOX_STEP if position < BOX_STEP.
- R9: Outside active video in pattern mode, data is 16'h1080.
- R10: The pattern is shown when sel_pattern=1 or live_valid=0. Otherwise the live data, de, hs and vs appear at the outputs one clock after they are sampled.
- R11: The source choice is taken only on the clock where the generator is at column 0, line 0. Input changes at any other time have no effect until that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_pattern | input | 1 | 1 forces the generated pattern |
| live_valid | input | 1 | Live source is present and usable |
| live_data | input | 16 | Live pixel data |
| live_de | input | 1 | Live data-enable |
| live_hs | input | 1 | Live horizontal sync |
| live_vs | input | 1 | Live vertical sync |
| vid_data | output | 16 | Output pixel, luma high byte, chroma low byte |
| vid_de | output | 1 | Output data-enable |
| vid_hs | output | 1 | Output horizontal sync |
| vid_vs | output | 1 | Output vertical sync |

## Verification
The assertions check several properties on every cycle. The line counter wraps and the line number advances only at the end of a line. The source choice holds between frame starts. The square stays still except on the blanking-start clock, and on that clock it moves by exactly one step. The square never leaves the active area. In pattern mode, data-enable never coincides with a sync pulse.

Only the bench scenarios can confirm the exact bar colors, the chroma alternation, the square's overlay and its bounce path over many frames. The bench also checks the one-clock pass-through, that select toggles in mid-frame are ignored, and the restart after a reset asserted in mid-run.

// File: rtl/cbg_pkg.sv
package cbg_pkg;

    typedef struct packed {
        logic [7:0] y;
        logic [7:0] cb;
        logic [7:0] cr;
    } ycc_t;

    localparam ycc_t BLANK_YCC = '{y: 8'd16, cb: 8'd128, cr: 8'd128};
    localparam ycc_t BOX_YCC   = '{y: 8'd81, cb: 8'd90,  cr: 8'd240};
    localparam int   NUM_BARS  = 8;

    function automatic ycc_t bar_ycc(input logic [2:0] idx);
        ycc_t c;
        case (idx)
            3'd0:    c = '{y: 8'd235, cb: 8'd128, cr: 8'd128};
            3'd1:    c = '{y: 8'd219, cb: 8'd16,  cr: 8'd138};
            3'd2:    c = '{y: 8'd188, cb: 8'd154, cr: 8'd16};
            3'd3:    c = '{y: 8'd173, cb: 8'd42,  cr: 8'd26};
            3'd4:    c = '{y: 8'd78,  cb: 8'd214, cr: 8'd230};
            3'd5:    c = '{y: 8'd63,  cb: 8'd102, cr: 8'd240};
            3'd6:    c = '{y: 8'd32,  cb: 8'd240, cr: 8'd118};
            default: c = '{y: 8'd16,  cb: 8'd128, cr: 8'd128};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cbg_timing.sv
module cbg_timing #(
    parameter int H_ACTIVE = 1920,
    parameter int H_FRONT  = 88,
    parameter int H_SYNC   = 44,
    parameter int H_BACK   = 148,
    parameter int V_ACTIVE = 1080,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 36,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          active,
    output logic          hsync,
    output logic          vsync,
    output logic          frame_start,
    output logic          vblank_start
);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (int'(cnt_q.h) == H_TOTAL - 1) begin
            cnt_d.h = '0;
            if (int'(cnt_q.v) == V_TOTAL - 1) begin
                cnt_d.v = '0;
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        h_cnt        = cnt_q.h;
        v_cnt        = cnt_q.v;
        active       = (int'(cnt_q.h) < H_ACTIVE) && (int'(cnt_q.v) < V_ACTIVE);
        hsync        = (int'(cnt_q.h) >= H_ACTIVE + H_FRONT) &&
                       (int'(cnt_q.h) <  H_ACTIVE + H_FRONT + H_SYNC);
        vsync        = (int'(cnt_q.v) >= V_ACTIVE + V_FRONT) &&
                       (int'(cnt_q.v) <  V_ACTIVE + V_FRONT + V_SYNC);
        frame_start  = (cnt_q.h == '0) && (cnt_q.v == '0);
        vblank_start = (cnt_q.h == '0) && (int'(cnt_q.v) == V_ACTIVE);
    end

endmodule

// File: rtl/cbg_axis.sv
module cbg_axis #(
    parameter int LIMIT = 1920,
    parameter int SIZE  = 128,
    parameter int STEP  = 4,
    parameter int W     = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_en,
    output logic [W-1:0] pos
);

    typedef struct packed {
        logic [W-1:0] pos;
        logic         neg;
    } axis_t;

    axis_t ax_d, ax_q;

    always_comb begin
        int p;
        ax_d = ax_q;
        p    = int'(ax_q.pos);
        if (step_en) begin
            if (!ax_q.neg) begin
                if (p + STEP + SIZE > LIMIT) begin
                    ax_d.neg = 1'b1;
                    ax_d.pos = W'(p - STEP);
                end else begin
                    ax_d.pos = W'(p + STEP);
                end
            end else begin
                if (p < STEP) begin
                    ax_d.neg = 1'b0;
                    ax_d.pos = W'(p + STEP);
                end else begin
                    ax_d.pos = W'(p - STEP);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ax_q <= '0;
        end else begin
            ax_q <= ax_d;
        end
    end

    assign pos = ax_q.pos;

endmodule

// File: rtl/colorbar_box_gen.sv
module colorbar_box_gen #(
    parameter int H_ACTIVE = 1920,
    parameter int H_FRONT  = 88,
    parameter int H_SYNC   = 44,
    parameter int H_BACK   = 148,
    parameter int V_ACTIVE = 1080,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 36,
    parameter int BOX_SIZE = 128,
    parameter int BOX_STEP = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel_pattern,
    input  logic        live_valid,
    input  logic [15:0] live_data,
    input  logic        live_de,
    input  logic        live_hs,
    input  logic        live_vs,
    output logic [15:0] vid_data,
    output logic        vid_de,
    output logic        vid_hs,
    output logic        vid_vs
);
    import cbg_pkg::*;

    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK;
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK;
    localparam int HW      = $clog2(H_TOTAL);
    localparam int VW      = $clog2(V_TOTAL);
    localparam int BAR_W   = H_ACTIVE / NUM_BARS;

    typedef struct packed {
        logic        src_pat;
        logic [15:0] data;
        logic        de;
        logic        hs;
        logic        vs;
    } out_t;

    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          active, hsync, vsync, frame_start, vblank_start;
    logic [HW-1:0] box_x;
    logic [VW-1:0] box_y;
    logic          src_pat;
    out_t          q_d, q_q;

    cbg_timing #(
        .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
        .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_cnt       (h_cnt),
        .v_cnt       (v_cnt),
        .active      (active),
        .hsync       (hsync),
        .vsync       (vsync),
        .frame_start (frame_start),
        .vblank_start(vblank_start)
    );

    cbg_axis #(.LIMIT(H_ACTIVE), .SIZE(BOX_SIZE), .STEP(BOX_STEP), .W(HW)) u_axis_x (
        .clk(clk), .rst_n(rst_n), .step_en(vblank_start), .pos(box_x)
    );

    cbg_axis #(.LIMIT(V_ACTIVE), .SIZE(BOX_SIZE), .STEP(BOX_STEP), .W(VW)) u_axis_y (
        .clk(clk), .rst_n(rst_n), .step_en(vblank_start), .pos(box_y)
    );

    always_comb begin
        int   x, y, bx, by;
        logic in_box;
        logic use_pat;
        ycc_t col;

        q_d = q_q;
        x   = int'(h_cnt);
        y   = int'(v_cnt);
        bx  = int'(box_x);
        by  = int'(box_y);

        use_pat = frame_start ? (sel_pattern | ~live_valid) : q_q.src_pat;

        in_box = (x >= bx) && (x < bx + BOX_SIZE) && (y >= by) && (y < by + BOX_SIZE);
        col    = in_box ? BOX_YCC : bar_ycc(3'(x / BAR_W));
        if (!active) begin
            col = BLANK_YCC;
        end

        q_d.src_pat = use_pat;
        if (use_pat) begin
            q_d.data = {col.y, h_cnt[0] ? col.cr : col.cb};
            q_d.de   = active;
            q_d.hs   = hsync;
            q_d.vs   = vsync;
        end else begin
            q_d.data = live_data;
            q_d.de   = live_de;
            q_d.hs   = live_hs;
            q_d.vs   = live_vs;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{src_pat: 1'b1, data: {BLANK_YCC.y, BLANK_YCC.cb}, de: 1'b0, hs: 1'b0, vs: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign src_pat  = q_q.src_pat;
    assign vid_data = q_q.data;
    assign vid_de   = q_q.de;
    assign vid_hs   = q_q.hs;
    assign vid_vs   = q_q.vs;

endmodule

// File: rtl/cbg_checker.sv
module cbg_checker #(
    parameter int H_ACTIVE = 1920,
    parameter int H_FRONT  = 88,
    parameter int H_SYNC   = 44,
    parameter int H_BACK   = 148,
    parameter int V_ACTIVE = 1080,
    parameter int V_FRONT  = 4,
    parameter int V_SYNC   = 5,
    parameter int V_BACK   = 36,
    parameter int BOX_SIZE = 128,
    parameter int BOX_STEP = 4,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [HW-1:0] h_cnt,
    input logic [VW-1:0] v_cnt,
    input logic          src_pat,
    input logic [HW-1:0] box_x,
    input logic [VW-1:0] box_y,
    input logic          vid_de,
    input logic          vid_hs,
    input logic          vid_vs
);

    assert_h_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(h_cnt) < H_TOTAL);

    assert_h_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_cnt) == H_TOTAL - 1) |=> (h_cnt == '0));

    assert_v_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_cnt) == H_TOTAL - 1 && int'(v_cnt) != V_TOTAL - 1)
        |=> (int'(v_cnt) == int'($past(v_cnt)) + 1));

    assert_v_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(h_cnt) != H_TOTAL - 1) |=> $stable(v_cnt));

    assert_src_frame_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_cnt == '0 && v_cnt == '0) |=> $stable(src_pat));

    assert_box_still_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(h_cnt == '0 && int'(v_cnt) == V_ACTIVE) |=> ($stable(box_x) && $stable(box_y)));

    assert_box_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_cnt == '0 && int'(v_cnt) == V_ACTIVE)
        |=> ((int'(box_x) - int'($past(box_x)) == BOX_STEP) ||
             (int'($past(box_x)) - int'(box_x) == BOX_STEP)));

    assert_box_inside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(box_x) + BOX_SIZE <= H_ACTIVE) && (int'(box_y) + BOX_SIZE <= V_ACTIVE));

    assert_pat_de_no_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        src_pat |-> !(vid_de && (vid_hs || vid_vs)));

endmodule

bind colorbar_box_gen cbg_checker #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .BOX_SIZE(BOX_SIZE), .BOX_STEP(BOX_STEP)
) u_chk (
    .clk(clk), .rst_n(rst_n), .h_cnt(h_cnt), .v_cnt(v_cnt), .src_pat(src_pat),
    .box_x(box_x), .box_y(box_y), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs)
);

// File: tb/colorbar_box_gen_tb.sv
module colorbar_box_gen_tb;

    localparam int HA = 64, HF = 4, HS = 4, HB = 8;
    localparam int VA = 32, VF = 2, VS = 2, VB = 4;
    localparam int BOX = 16, STEP = 4;
    localparam int HT = HA + HF + HS + HB;
    localparam int VT = VA + VF + VS + VB;
    localparam int F  = HT * VT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_pattern = 1'b0;
    logic        live_valid = 1'b0;
    logic [15:0] live_data = '0;
    logic        live_de = 1'b0, live_hs = 1'b0, live_vs = 1'b0;
    logic [15:0] vid_data;
    logic        vid_de, vid_hs, vid_vs;

    always #4 clk = ~clk;

    colorbar_box_gen #(
        .H_ACTIVE(HA), .H_FRONT(HF), .H_SYNC(HS), .H_BACK(HB),
        .V_ACTIVE(VA), .V_FRONT(VF), .V_SYNC(VS), .V_BACK(VB),
        .BOX_SIZE(BOX), .BOX_STEP(STEP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_pattern(sel_pattern), .live_valid(live_valid),
        .live_data(live_data), .live_de(live_de), .live_hs(live_hs), .live_vs(live_vs),
        .vid_data(vid_data), .vid_de(vid_de), .vid_hs(vid_hs), .vid_vs(vid_vs)
    );

    int errors = 0;
    int checks = 0;
    int n = 0;
    int bx = 0, by = 0;
    bit nx = 0, ny = 0;
    bit pat = 1;
    bit done = 0;

    // R4 bar colors, R6 square color: {Y, Cb, Cr}
    function automatic logic [23:0] exp_color(int x, int y);
        if (x >= bx && x < bx + BOX && y >= by && y < by + BOX) return {8'd81, 8'd90, 8'd240};
        case (x / (HA / 8))
            0: return {8'd235, 8'd128, 8'd128};
            1: return {8'd219, 8'd16,  8'd138};
            2: return {8'd188, 8'd154, 8'd16};
            3: return {8'd173, 8'd42,  8'd26};
            4: return {8'd78,  8'd214, 8'd230};
            5: return {8'd63,  8'd102, 8'd240};
            6: return {8'd32,  8'd240, 8'd118};
            default: return {8'd16, 8'd128, 8'd128};
        endcase
    endfunction

    // R7 / R8 one frame step of the square
    task automatic move_box();
        if (!nx) begin
            if (bx + STEP + BOX > HA) begin nx = 1; bx -= STEP; end else bx += STEP;
        end else begin
            if (bx < STEP) begin nx = 0; bx += STEP; end else bx -= STEP;
        end
        if (!ny) begin
            if (by + STEP + BOX > VA) begin ny = 1; by -= STEP; end else by += STEP;
        end else begin
            if (by < STEP) begin ny = 0; by += STEP; end else by -= STEP;
        end
    endtask

    // inputs for posedge index m: directed source choice in the first half of
    // each frame, random toggles in the second half (R11: must be ignored)
    task automatic drive(int m);
        int ph;
        ph = (m / F) % 4;
        if (m % F < F / 2) begin
            case (ph)
                0: begin sel_pattern = 1'b0; live_valid = 1'b1; end
                1: begin sel_pattern = 1'b1; live_valid = 1'b1; end
                2: begin sel_pattern = 1'b0; live_valid = 1'b0; end
                default: begin sel_pattern = 1'($urandom); live_valid = 1'($urandom); end
            endcase
        end else begin
            sel_pattern = 1'($urandom);
            live_valid  = 1'($urandom);
        end
        live_data = 16'($urandom);
        live_de   = 1'($urandom);
        live_hs   = 1'($urandom);
        live_vs   = 1'($urandom);
    endtask

    task automatic step_cycle();
        int h, v;
        logic [15:0] ed;
        logic ede, ehs, evs;
        logic [23:0] c;
        string tag;
        @(negedge clk);
        h = n % HT;
        v = (n / HT) % VT;
        if (n % F == 0) pat = sel_pattern || !live_valid;   // R10 R11
        if (!pat) begin
            ed = live_data; ede = live_de; ehs = live_hs; evs = live_vs;
        end else begin
            ede = (h < HA) && (v < VA);
            ehs = (h >= HA + HF) && (h < HA + HF + HS);
            evs = (v >= VA + VF) && (v < VA + VF + VS);
            if (!ede) begin
                ed = 16'h1080;
            end else begin
                c  = exp_color(h, v);
                ed = {c[23:16], (h % 2 == 1) ? c[7:0] : c[15:8]};
            end
        end
        checks++;
        if ({vid_data, vid_de, vid_hs, vid_vs} !== {ed, ede, ehs, evs}) begin
            errors++;
            if (!pat) tag = "R10 R11 pass-through";
            else if (vid_de !== ede || vid_hs !== ehs) tag = "R2 R11 line timing";
            else if (vid_vs !== evs) tag = "R3 frame timing";
            else if (!ede) tag = "R9 blank data";
            else if (h >= bx && h < bx + BOX && v >= by && v < by + BOX) tag = "R6 R7 R8 square";
            else tag = "R4 R5 bars";
            $display("FAIL %s n=%0d h=%0d v=%0d actual=%h/%b%b%b expected=%h/%b%b%b",
                     tag, n, h, v, vid_data, vid_de, vid_hs, vid_vs, ed, ede, ehs, evs);
        end
        if (n % F == VA * HT) move_box();
        n++;
        drive(n);
    endtask

    // R1: reset state, then restart at pixel (0,0)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            checks++;
            if ({vid_data, vid_de, vid_hs, vid_vs} !== {16'h1080, 3'b000}) begin
                errors++;
                $display("FAIL R1 reset state actual=%h/%b%b%b expected=1080/000",
                         vid_data, vid_de, vid_hs, vid_vs);
            end
        end
        n = 0; bx = 0; by = 0; nx = 0; ny = 0; pat = 1;
        drive(0);
        rst_n = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        repeat (20 * F) step_cycle();
        do_reset();                       // R1 mid-run reset
        repeat (14 * F) step_cycle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired n=%0d", n);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule